// File: doc/BRIEF.md
# Two-Processor Byte Mailbox

This block joins a controlling processor (the master) to a subordinate processor (the slave) through two one-byte mailboxes, one for each direction. Each side has its own small register bus: an address, a write strobe, a read strobe, write data and combinational read data. Writing the data address on one side fills the mailbox toward the other side. Reading the data address on the other side takes the byte and empties that mailbox. The fill state of both mailboxes appears in a status byte that either processor can read at any time without side effects.

A byte arriving for the slave raises an active-high interrupt toward it. A byte arriving for the master pulls an active-low attention line. Because any write counts, a write of a throwaway value works purely as a doorbell, and the receiver's read of the data address serves as the acknowledgement. Message framing, lengths and type codes are left to software.

Top module: `mbox_link`

## Requirements
- R1: A master write to address 0 stores the byte in the master-to-slave mailbox and sets its full flag, so `s_irq` is high from the next cycle. The value of the byte does not matter, and 0x00 counts as well. The slave reads the stored byte at its own address 0.
- R2: A slave read of address 0 empties the master-to-slave mailbox, and `s_irq` is low from the next cycle.
- R3: A slave write to address 0 stores the byte in the slave-to-master mailbox and sets its full flag, so `m_attn_n` is low from the next cycle. The master reads the byte at its own address 0.
- R4: A master read of address 0 empties the slave-to-master mailbox, and `m_attn_n` returns high from the next cycle.
- R5: Address 1 on either side reads a status byte. Bit 0 is the master-to-slave full flag, bit 1 is the slave-to-master full flag, and the other bits are zero. Reading the status changes no state.
- R6: A write to a mailbox that is already full replaces the byte, and the flag stays set.
- R7: Reading an empty mailbox returns the byte it last held and leaves the flags unchanged.
- R8: When a write and a read of the same mailbox fall in the same cycle, the write wins: the mailbox holds the new byte and stays full. The read in that cycle returns the previous byte.
- R9: A synchronous active-high reset clears both flags and both stored bytes. After reset `s_irq` is low and `m_attn_n` is high.
- R10: Addresses 2 and 3 read as zero on both sides, and reads or writes there change no state.
- R11: The two directions are independent. A master write and a slave write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | AW | Master register address |
| m_wr | input | 1 | Master write strobe |
| m_rd | input | 1 | Master read strobe (side effects only) |
| m_wdata | input | DW | Master write data |
| m_rdata | output | DW | Master read data, combinational from `m_addr` |
| s_addr | input | AW | Slave register address |
| s_wr | input | 1 | Slave write strobe |
| s_rd | input | 1 | Slave read strobe (side effects only) |
| s_wdata | input | DW | Slave write data |
| s_rdata | output | DW | Slave read data, combinational from `s_addr` |
| s_irq | output | 1 | Slave interrupt, high while the master-to-slave mailbox is full |
| m_attn_n | output | 1 | Master attention, low while the slave-to-master mailbox is full |

## Verification
The hardest case to reach from the ports is the collision: a master write and a slave read of a full master-to-slave mailbox in the same cycle. The bench first fills the mailbox. It then drives both strobes in a single cycle and samples `s_rdata` before the edge, expecting the old byte. After the edge it expects the new byte and the flag still set. Doorbell writes of 0x00 and writes to the unmapped addresses are also driven, to show that the byte value never gates the flag and that the spare addresses touch nothing.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int ADDR_DATA = 0;
  localparam int ADDR_STAT = 1;
  localparam int N_DIR     = 2;   // 0: master->slave, 1: slave->master

  // Status byte: bit0 = m2s full, bit1 = s2m full, rest zero.
  function automatic logic [7:0] status_byte(input logic m2s_full, input logic s2m_full);
    logic [7:0] s;
    s    = 8'h00;
    s[0] = m2s_full;
    s[1] = s2m_full;
    return s;
  endfunction
endpackage

// File: rtl/mbox_chan.sv
`timescale 1ns/1ps
// One direction: a data byte plus its full flag. Write wins over read.
module mbox_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          ev_fill,
  output logic          ev_drain
);
  logic [DW-1:0] data_q;
  logic          full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (push) data_q <= din;
      if (push)     full_q <= 1'b1;
      else if (pop) full_q <= 1'b0;
    end
  end

  assign ev_fill  = push;
  assign ev_drain = pop & ~push & full_q;
  assign dout     = data_q;
  assign full     = full_q;
endmodule

// File: rtl/mbox_side.sv
`timescale 1ns/1ps
// Register-bus decode for one processor side.
module mbox_side
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] rx_data,
  input  logic [7:0]    stat,
  output logic          push,
  output logic          pop,
  output logic [DW-1:0] rdata
);
  localparam logic [AW-1:0] A_DATA = AW'(ADDR_DATA);
  localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);

  logic hit_data, hit_stat;
  assign hit_data = (addr == A_DATA);
  assign hit_stat = (addr == A_STAT);
  assign push     = wr & hit_data;
  assign pop      = rd & hit_data;

  always_comb begin
    rdata = '0;
    if (hit_data)      rdata = rx_data;
    else if (hit_stat) rdata = DW'(stat);
  end
endmodule

// File: rtl/mbox_link.sv
`timescale 1ns/1ps
module mbox_link
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] m_addr,
  input  logic          m_wr,
  input  logic          m_rd,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] m_rdata,
  input  logic [AW-1:0] s_addr,
  input  logic          s_wr,
  input  logic          s_rd,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  output logic          s_irq,
  output logic          m_attn_n
);
  // Index i: side i (0 master, 1 slave) pushes channel i and pops channel 1-i.
  logic [N_DIR-1:0][AW-1:0] side_addr;
  logic [N_DIR-1:0]         side_wr, side_rd;
  logic [N_DIR-1:0][DW-1:0] side_wdata, side_rdata;
  logic [N_DIR-1:0]         side_push, side_pop;
  logic [N_DIR-1:0][DW-1:0] chan_data;
  logic [N_DIR-1:0]         chan_full, chan_fill, chan_drain;
  logic [7:0]               stat;

  assign side_addr[0]  = m_addr;   assign side_addr[1]  = s_addr;
  assign side_wr[0]    = m_wr;     assign side_wr[1]    = s_wr;
  assign side_rd[0]    = m_rd;     assign side_rd[1]    = s_rd;
  assign side_wdata[0] = m_wdata;  assign side_wdata[1] = s_wdata;

  assign stat = status_byte(chan_full[0], chan_full[1]);

  for (genvar i = 0; i < N_DIR; i++) begin : g_dir
    mbox_side #(.DW(DW), .AW(AW)) u_side (
      .addr    (side_addr[i]),
      .wr      (side_wr[i]),
      .rd      (side_rd[i]),
      .rx_data (chan_data[N_DIR-1-i]),
      .stat    (stat),
      .push    (side_push[i]),
      .pop     (side_pop[i]),
      .rdata   (side_rdata[i])
    );
    mbox_chan #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .push     (side_push[i]),
      .din      (side_wdata[i]),
      .pop      (side_pop[N_DIR-1-i]),
      .dout     (chan_data[i]),
      .full     (chan_full[i]),
      .ev_fill  (chan_fill[i]),
      .ev_drain (chan_drain[i])
    );
  end

  assign m_rdata  = side_rdata[0];
  assign s_rdata  = side_rdata[1];
  assign s_irq    = chan_full[0];
  assign m_attn_n = ~chan_full[1];
endmodule

// File: rtl/mbox_link_chk.sv
`timescale 1ns/1ps
module mbox_link_chk
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] m_addr,
  input logic          m_wr,
  input logic          m_rd,
  input logic [DW-1:0] m_rdata,
  input logic [AW-1:0] s_addr,
  input logic          s_wr,
  input logic          s_rd,
  input logic          s_irq,
  input logic          m_attn_n
);
  localparam logic [AW-1:0] A_DATA = AW'(ADDR_DATA);
  localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);

  logic m_push, s_pop, s_push, m_pop;
  assign m_push = m_wr && (m_addr == A_DATA);
  assign s_pop  = s_rd && (s_addr == A_DATA);
  assign s_push = s_wr && (s_addr == A_DATA);
  assign m_pop  = m_rd && (m_addr == A_DATA);

  assert_fill_irq_R1: assert property (@(posedge clk) disable iff (rst)
    m_push |=> s_irq);
  assert_drain_irq_R2: assert property (@(posedge clk) disable iff (rst)
    (s_pop && !m_push) |=> !s_irq);
  assert_fill_attn_R3: assert property (@(posedge clk) disable iff (rst)
    s_push |=> !m_attn_n);
  assert_drain_attn_R4: assert property (@(posedge clk) disable iff (rst)
    (m_pop && !s_push) |=> m_attn_n);
  assert_status_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (m_addr == A_STAT) |-> (m_rdata[1:0] == {!m_attn_n, s_irq} && m_rdata[DW-1:2] == '0));
  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!m_push && !s_pop) |=> $stable(s_irq));
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!s_irq && m_attn_n));
endmodule

bind mbox_link mbox_link_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
  .m_rdata(m_rdata), .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd),
  .s_irq(s_irq), .m_attn_n(m_attn_n)
);

// File: tb/tb_mbox_link.sv
`timescale 1ns/1ps
module tb_mbox_link;
  localparam int DW = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] m_addr = '0, s_addr = '0;
  logic          m_wr = 0, m_rd = 0, s_wr = 0, s_rd = 0;
  logic [DW-1:0] m_wdata = '0, s_wdata = '0;
  logic [DW-1:0] m_rdata, s_rdata;
  logic          s_irq, m_attn_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mbox_link #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst),
    .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .s_addr(s_addr), .s_wr(s_wr), .s_rd(s_rd), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .s_irq(s_irq), .m_attn_n(m_attn_n)
  );

  // Expected status byte, written independently of the design package.
  function automatic logic [7:0] exp_stat(input bit m2s, input bit s2m);
    return {6'b0, s2m, m2s};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // One bus cycle: drive strobes now, let one rising edge pass, idle, settle.
  task automatic step(input bit mw, input bit mr, input logic [AW-1:0] ma, input logic [DW-1:0] md,
                      input bit sw, input bit sr, input logic [AW-1:0] sa, input logic [DW-1:0] sd);
    m_wr = mw; m_rd = mr; m_addr = ma; m_wdata = md;
    s_wr = sw; s_rd = sr; s_addr = sa; s_wdata = sd;
    @(negedge clk);
    m_wr = 0; m_rd = 0; s_wr = 0; s_rd = 0;
    #0.2;
  endtask

  task automatic peek(input logic [AW-1:0] ma, input logic [AW-1:0] sa,
                      output logic [DW-1:0] mv, output logic [DW-1:0] sv);
    m_addr = ma; s_addr = sa;
    #0.2;
    mv = m_rdata; sv = s_rdata;
  endtask

  task automatic t_reset();
    logic [DW-1:0] mv, sv;
    check("R9 s_irq", s_irq, 0);
    check("R9 m_attn_n", m_attn_n, 1);
    peek(1, 1, mv, sv);
    check("R9 status m", mv, 0);
    check("R9 status s", sv, 0);
    peek(0, 0, mv, sv);
    check("R9 data m", mv, 0);
    check("R9 data s", sv, 0);
  endtask

  task automatic t_m2s();
    logic [DW-1:0] mv, sv;
    step(1, 0, 0, 8'hA5, 0, 0, 0, 0);
    check("R1 s_irq", s_irq, 1);
    peek(0, 0, mv, sv);
    check("R1 slave data", sv, 8'hA5);
    peek(1, 1, mv, sv);
    check("R1 status s", sv, exp_stat(1, 0));
    step(0, 0, 0, 0, 0, 1, 0, 0);
    check("R2 s_irq", s_irq, 0);
    peek(1, 1, mv, sv);
    check("R2 status m", mv, exp_stat(0, 0));
  endtask

  task automatic t_s2m();
    logic [DW-1:0] mv, sv;
    step(0, 0, 0, 0, 1, 0, 0, 8'h3C);
    check("R3 m_attn_n", m_attn_n, 0);
    peek(0, 0, mv, sv);
    check("R3 master data", mv, 8'h3C);
    peek(1, 1, mv, sv);
    check("R3 status m", mv, exp_stat(0, 1));
    step(0, 1, 0, 0, 0, 0, 0, 0);
    check("R4 m_attn_n", m_attn_n, 1);
    peek(1, 1, mv, sv);
    check("R4 status s", sv, exp_stat(0, 0));
  endtask

  task automatic t_doorbell();
    logic [DW-1:0] mv, sv;
    step(1, 0, 0, 8'h00, 0, 0, 0, 0);
    check("R1 zero-byte doorbell irq", s_irq, 1);
    peek(0, 0, mv, sv);
    check("R1 zero-byte data", sv, 8'h00);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    check("R2 doorbell ack", s_irq, 0);
  endtask

  task automatic t_overwrite_empty();
    logic [DW-1:0] mv, sv;
    step(1, 0, 0, 8'h11, 0, 0, 0, 0);
    step(1, 0, 0, 8'h22, 0, 0, 0, 0);
    check("R6 still full", s_irq, 1);
    peek(0, 0, mv, sv);
    check("R6 overwritten data", sv, 8'h22);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    check("R6 single read drains", s_irq, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    check("R7 empty read keeps empty", s_irq, 0);
    peek(0, 0, mv, sv);
    check("R7 last value", sv, 8'h22);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    check("R7 empty master read attn", m_attn_n, 1);
  endtask

  task automatic t_status();
    logic [DW-1:0] mv, sv;
    step(1, 0, 0, 8'h5A, 1, 0, 0, 8'hC3);
    check("R11 both irq", s_irq, 1);
    check("R11 both attn", m_attn_n, 0);
    peek(0, 0, mv, sv);
    check("R11 m sees s byte", mv, 8'hC3);
    check("R11 s sees m byte", sv, 8'h5A);
    for (int k = 0; k < 3; k++) step(0, 1, 1, 0, 0, 1, 1, 0);
    peek(1, 1, mv, sv);
    check("R5 status m both", mv, exp_stat(1, 1));
    check("R5 status s both", sv, exp_stat(1, 1));
    check("R5 irq undisturbed", s_irq, 1);
    check("R5 attn undisturbed", m_attn_n, 0);
    step(0, 1, 0, 0, 0, 1, 0, 0);
    check("R2 drain both irq", s_irq, 0);
    check("R4 drain both attn", m_attn_n, 1);
  endtask

  task automatic t_collide();
    logic [DW-1:0] mv, sv;
    step(1, 0, 0, 8'h44, 0, 0, 0, 0);
    m_wr = 1; m_addr = 0; m_wdata = 8'h55;
    s_rd = 1; s_addr = 0;
    #0.2;
    check("R8 read sees old byte", s_rdata, 8'h44);
    @(negedge clk);
    m_wr = 0; s_rd = 0;
    #0.2;
    check("R8 stays full", s_irq, 1);
    peek(0, 0, mv, sv);
    check("R8 new byte held", sv, 8'h55);
    step(0, 0, 0, 0, 1, 0, 0, 8'h66);
    m_rd = 1; m_addr = 0; s_wr = 1; s_addr = 0; s_wdata = 8'h77;
    @(negedge clk);
    m_rd = 0; s_wr = 0;
    #0.2;
    check("R8 s2m stays full", m_attn_n, 0);
    peek(0, 0, mv, sv);
    check("R8 s2m new byte", mv, 8'h77);
    step(0, 1, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] mv, sv;
    step(1, 0, 0, 8'h9E, 0, 0, 0, 0);
    for (int a = 2; a < 4; a++) begin
      step(1, 1, AW'(a), 8'hFF, 1, 1, AW'(a), 8'hEE);
      peek(AW'(a), AW'(a), mv, sv);
      check("R10 master unmapped read", mv, 0);
      check("R10 slave unmapped read", sv, 0);
    end
    check("R10 irq kept", s_irq, 1);
    check("R10 attn kept", m_attn_n, 1);
    peek(0, 0, mv, sv);
    check("R10 m2s data kept", sv, 8'h9E);
    check("R10 s2m data kept", mv, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #0.2;
    t_reset();
    t_m2s();
    t_s2m();
    t_doorbell();
    t_overwrite_empty();
    t_status();
    t_collide();
    t_unmapped();
    // Reset from a loaded state.
    step(0, 0, 0, 0, 1, 0, 0, 8'h12);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #0.2;
    check("R9 re-reset irq", s_irq, 0);
    check("R9 re-reset attn", m_attn_n, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule